// File: doc/BRIEF.md
# Periodic event timer comparator

This block is one timer channel. It watches a free-running main counter that lives outside the block. On every cycle in which that counter advances, the channel compares the new count with its comparator register. An equal count is a match. A match sets a sticky status bit and, when the channel is enabled, drives the interrupt line.

The channel has two modes:
- **One-shot mode:** the comparator keeps the value software last wrote.
- **Periodic mode:** after each match the hardware adds the stored period to the comparator, wrapping modulo the timer width, so that matches recur at a fixed spacing.

The interrupt line also has two forms:
- **Edge form:** each match gives a one-cycle pulse.
- **Level form:** the line follows the sticky status bit, and software clears that bit by writing one to it.

Software reaches the channel through a small word-wide register port. Writes are single-cycle strobes. Reads are combinational on the selected address. The port has no handshake, because the registers accept a write on every cycle.

Top module: `evt_timer_chan`

## Requirements
- R1: After reset the comparator reads all ones over TW bits, the configuration reads 0, the status reads 0 and `irq` is low. The period register resets to 0.
- R2: A write to address 0 loads both the comparator and the period register with `reg_wdata` at the next clock. A read of address 0 returns the current comparator, including any hardware advance.
- R3: A comparator write never causes a match by itself. A match always uses the comparator value held before the write.
- R4: In one-shot mode (configuration bit 2 = 0), a match leaves the comparator unchanged.
- R5: In periodic mode (configuration bit 2 = 1), each match adds the period to the comparator at the next clock. For example, a write of 123h gives matches at 123h, 246h and 369h. A write on the same cycle as a match takes priority over the addition.
- R6: The periodic addition wraps modulo 2^TW. For example, FFFF0000h plus FFFF0000h gives FFFE0000h.
- R7: When the enable bit (configuration bit 0) is 0, a match still sets the status bit but `irq` stays low.
- R8: In edge form (configuration bit 1 = 0) with the channel enabled, `irq` is high for exactly the one cycle that follows each match.
- R9: In level form (configuration bit 1 = 1) with the channel enabled, `irq` equals the status bit. The line rises the cycle after a match and stays high until the status is cleared. A further match keeps it high.
- R10: Status bit 0 at address 2 is set by a match and cleared by writing 1 to it. A write of 0 does nothing. A match in the same cycle as a clear leaves the status set.
- R11: A match needs `cnt_tick` high. An equal `cnt_val` without `cnt_tick` changes no state.
- R12: Address 1 reads back {periodic, level, enable} in bits 2:0. Address 3 reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | High on each cycle in which the main counter has advanced |
| cnt_val | input | TW | Main counter value, valid when `cnt_tick` is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 comparator, 1 configuration, 2 status |
| reg_wdata | input | TW | Write data |
| reg_rdata | output | TW | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt output |

## Verification
A corrupted comparator or period register is seen in two ways:
- **At read-back:** a read of address 0 shows the wrong value on the very next cycle.
- **In match timing:** the effect is delayed. It shows only when a later count fails to match or matches early, which can be a whole period later.

A wrong status or pulse register shows on `irq` in the cycle after the match that should have produced it. In level form it also shows when a clear is ignored. The bench therefore reads back the comparator and the status after every cycle, so a fault is caught in the cycle it occurs rather than at the next interrupt.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Register select codes used on reg_addr
  typedef enum logic [1:0] {
    SEL_COMP = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Channel configuration; packed order gives bit2=periodic, bit1=level, bit0=en
  typedef struct packed {
    logic periodic;
    logic level;
    logic en;
  } tcfg_t;

  localparam int CFG_W = $bits(tcfg_t);

endpackage

// File: rtl/evt_cmp_unit.sv
module evt_cmp_unit #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  input  logic [TW-1:0] cnt,
  input  logic          periodic,
  output logic [TW-1:0] comp,
  output logic [TW-1:0] period,
  output logic          match
);

  logic [TW-1:0] comp_q;
  logic [TW-1:0] period_q;
  logic [TW-1:0] comp_next_sum;

  // Match against the registered comparator only; a write this cycle is not seen
  assign match         = tick && (cnt == comp_q);
  assign comp_next_sum = comp_q + period_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp_q   <= '1;
      period_q <= '0;
    end else if (load) begin
      comp_q   <= load_val;
      period_q <= load_val;
    end else if (match && periodic) begin
      comp_q   <= comp_next_sum;
    end
  end

  assign comp   = comp_q;
  assign period = period_q;

endmodule

// File: rtl/evt_status.sv
module evt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic sts
);

  logic sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   sts_q <= 1'b0;
    else if (set) sts_q <= 1'b1;
    else if (clr) sts_q <= 1'b0;
  end

  assign sts = sts_q;

endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic en,
  input  logic level,
  input  logic sts,
  output logic irq
);

  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= match && en && !level;
  end

  assign irq = pulse_q || (en && level && sts);

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic [TW-1:0] cnt_val,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [TW-1:0] reg_wdata,
  output logic [TW-1:0] reg_rdata,
  output logic          irq
);
  import evt_pkg::*;

  reg_sel_e      sel;
  tcfg_t         cfg_q;
  logic          wr_comp, wr_cfg, wr_stat;
  logic [TW-1:0] comp_w, period_w;
  logic          match_w;
  logic          sts_w;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_comp = reg_wr && (sel == SEL_COMP);
  assign wr_cfg  = reg_wr && (sel == SEL_CFG);
  assign wr_stat = reg_wr && (sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= tcfg_t'(reg_wdata[CFG_W-1:0]);
  end

  evt_cmp_unit #(.TW(TW)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_comp),
    .load_val (reg_wdata),
    .tick     (cnt_tick),
    .cnt      (cnt_val),
    .periodic (cfg_q.periodic),
    .comp     (comp_w),
    .period   (period_w),
    .match    (match_w)
  );

  evt_status u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (match_w),
    .clr   (wr_stat && reg_wdata[0]),
    .sts   (sts_w)
  );

  evt_irq_gen u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .match (match_w),
    .en    (cfg_q.en),
    .level (cfg_q.level),
    .sts   (sts_w),
    .irq   (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_COMP: reg_rdata = comp_w;
      SEL_CFG:  reg_rdata[CFG_W-1:0] = cfg_q;
      SEL_STAT: reg_rdata[0] = sts_w;
      SEL_NONE: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_timer_chan_chk.sv
module evt_timer_chan_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_tick,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [TW-1:0] reg_wdata,
  input logic [TW-1:0] comp,
  input logic [TW-1:0] period,
  input logic          match,
  input logic          cfg_en,
  input logic          cfg_level,
  input logic          cfg_periodic,
  input logic          sts,
  input logic          irq
);

  logic          wr_c;
  logic [TW-1:0] sum_c;

  assign wr_c  = reg_wr && (reg_addr == 2'd0);
  assign sum_c = comp + period;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> (comp == $past(reg_wdata)) && (period == $past(reg_wdata)));

  a_r4_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !cfg_periodic && !wr_c) |=> $stable(comp));

  a_r5_periodic_add: assert property (@(posedge clk) disable iff (!rst_n)
    (match && cfg_periodic && !wr_c) |=> (comp == $past(sum_c)));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_en || $past(cfg_en)));

  a_r8_edge_source: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_en && cfg_level && sts)) |-> $past(match && cfg_en && !cfg_level));

  a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_level && sts) |-> irq);

  a_r10_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> sts);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[0] && !match) |=> !sts);

  a_r11_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !reg_wr) |=> ($stable(comp) && !$rose(sts)));

endmodule

bind evt_timer_chan evt_timer_chan_chk #(.TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_tick     (cnt_tick),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .comp         (comp_w),
  .period       (period_w),
  .match        (match_w),
  .cfg_en       (cfg_q.en),
  .cfg_level    (cfg_q.level),
  .cfg_periodic (cfg_q.periodic),
  .sts          (sts_w),
  .irq          (irq)
);

// File: tb/evt_timer_chan_tb.sv
module evt_timer_chan_tb;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_tick = 1'b0;
  logic [TW-1:0] cnt_val = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [TW-1:0] reg_wdata = '0;
  logic [TW-1:0] reg_rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference model state
  logic [TW-1:0] m_comp, m_per;
  logic          m_en, m_lvl, m_pmode, m_sts, m_pulse;
  logic [TW-1:0] bcnt;

  always #10 clk = ~clk;  // 50 MHz

  evt_timer_chan #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return m_pulse | (m_en & m_lvl & m_sts);
  endfunction

  task automatic rd(input logic [1:0] a, output logic [TW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // one clock: drive at negedge, update the model at the edge, check at the next negedge
  task automatic step(input logic tk, input logic [TW-1:0] cv, input logic wr,
                      input logic [1:0] a, input logic [TW-1:0] wd, input string tag);
    logic mt;
    logic [TW-1:0] d;
    cnt_tick = tk; cnt_val = cv; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    mt = tk && (cv == m_comp);
    m_pulse = mt && m_en && !m_lvl;
    if (wr && a == 2'd0) begin m_comp = wd; m_per = wd; end
    else if (mt && m_pmode) m_comp = m_comp + m_per;
    if (mt) m_sts = 1'b1;
    else if (wr && a == 2'd2 && wd[0]) m_sts = 1'b0;
    if (wr && a == 2'd1) begin m_en = wd[0]; m_lvl = wd[1]; m_pmode = wd[2]; end
    @(negedge clk);
    reg_wr = 1'b0; cnt_tick = 1'b0;
    chk({tag, " irq"}, {{(TW-1){1'b0}}, irq}, {{(TW-1){1'b0}}, exp_irq()});
    rd(2'd0, d); chk({tag, " comp"}, d, m_comp);
    rd(2'd2, d); chk({tag, " status"}, d, {{(TW-1){1'b0}}, m_sts});
  endtask

  task automatic idle(input string tag);
    step(1'b0, cnt_val, 1'b0, 2'd3, '0, tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [TW-1:0] d;
    void'($urandom(32'd4242));
    m_comp = '1; m_per = '0; m_en = 0; m_lvl = 0; m_pmode = 0; m_sts = 0; m_pulse = 0;
    bcnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {{(TW-1){1'b0}}, irq}, '0);
    rd(2'd0, d); chk("R1 comp", d, '1);
    rd(2'd1, d); chk("R1 cfg", d, '0);
    rd(2'd2, d); chk("R1 status", d, '0);
    // R12 unused address and config readback
    rd(2'd3, d); chk("R12 addr3", d, '0);
    step(0, '0, 1, 2'd3, '1, "R12");
    step(0, '0, 1, 2'd1, 32'h5, "R12");
    rd(2'd1, d); chk("R12 cfg", d, 32'h5);
    rd(2'd3, d); chk("R12 addr3 after write", d, '0);

    // enabled, edge form, one-shot
    step(0, '0, 1, 2'd1, 32'h1, "R12");
    // R3: write 5 while the counter ticks onto 5: no match
    step(1, 32'd5, 1, 2'd0, 32'd5, "R3");
    rd(2'd2, d); chk("R3 no self match", d, '0);
    chk("R2 comp load", m_comp, 32'd5);
    // R11: equal count without tick
    step(0, 32'd5, 0, 2'd3, '0, "R11");
    // R4/R8: real match
    step(1, 32'd5, 0, 2'd3, '0, "R8");
    chk("R8 pulse high", {{(TW-1){1'b0}}, irq}, 32'd1);
    rd(2'd0, d); chk("R4 comp held", d, 32'd5);
    idle("R8");
    chk("R8 pulse one cycle", {{(TW-1){1'b0}}, irq}, '0);
    // R10 write-0 ignored, write-1 clears
    step(0, '0, 1, 2'd2, 32'h0, "R10");
    rd(2'd2, d); chk("R10 write0 ignored", d, 32'd1);
    step(0, '0, 1, 2'd2, 32'h1, "R10");
    rd(2'd2, d); chk("R10 write1 clears", d, '0);

    // R9 level form
    step(0, '0, 1, 2'd1, 32'h3, "R9");
    step(1, 32'd5, 0, 2'd3, '0, "R9");
    repeat (3) idle("R9");
    chk("R9 level held", {{(TW-1){1'b0}}, irq}, 32'd1);
    step(1, 32'd5, 0, 2'd3, '0, "R9");
    step(1, 32'd5, 1, 2'd2, 32'h1, "R10");
    rd(2'd2, d); chk("R10 clear with match keeps set", d, 32'd1);
    step(0, '0, 1, 2'd2, 32'h1, "R9");
    chk("R9 cleared low", {{(TW-1){1'b0}}, irq}, '0);

    // R5 periodic 123h sequence
    step(0, '0, 1, 2'd1, 32'h5, "R5");
    step(0, '0, 1, 2'd0, 32'h123, "R5");
    for (int i = 1; i <= 32'h36A; i++) step(1, TW'(i), 0, 2'd3, '0, "R5");
    rd(2'd0, d); chk("R5 after three matches", d, 32'h48C);

    // R6 wrap
    step(0, '0, 1, 2'd0, 32'hFFFF0000, "R6");
    step(1, 32'hFFFF0000, 0, 2'd3, '0, "R6");
    rd(2'd0, d); chk("R6 wrapped", d, 32'hFFFE0000);

    // R7 disabled: status set, irq quiet
    step(0, '0, 1, 2'd2, 32'h1, "R7");
    step(0, '0, 1, 2'd1, 32'h6, "R7");
    step(1, 32'hFFFE0000, 0, 2'd3, '0, "R7");
    rd(2'd2, d); chk("R7 status set", d, 32'd1);
    chk("R7 irq low", {{(TW-1){1'b0}}, irq}, '0);

    // random phase
    bcnt = '0;
    step(0, '0, 1, 2'd0, 32'd7, "R2");
    for (int i = 0; i < 4000; i++) begin
      logic tk, wr;
      logic [1:0] a;
      logic [TW-1:0] wd;
      string tg;
      tk = 1'($urandom % 2);
      if (tk) bcnt = bcnt + 1;
      wr = (($urandom % 12) == 0);
      a  = 2'($urandom % 4);
      case (a)
        2'd0: wd = bcnt + 1 + ($urandom % 9);
        2'd1: wd = TW'($urandom % 8);
        default: wd = TW'($urandom % 2);
      endcase
      if (!m_en) tg = "R7";
      else if (m_lvl) tg = "R9";
      else tg = "R8";
      if (m_pmode) tg = {tg, " R5"};
      else tg = {tg, " R4"};
      step(tk, bcnt, wr, a, wd, tg);
    end

    finished = 1;
    summary();
  end

endmodule